// File: doc/BRIEF.md
# Single-Upset-Correcting Serial Pattern Detector

This block watches a serial bit stream and raises a one-clock match pulse each time the most recent sixteen bits equal a fixed key. Inside, a sixteen-state sequencer counts how much of the key has been seen. The state register does not hold the plain state number. It holds a codeword from an error-correcting code with a minimum distance above three. The next-state and output logic decode that register before they use it. A single flipped bit anywhere in the register is therefore corrected before it can change the sequence or the match output.

Each clock reloads the register with a freshly encoded next state, so a corrected upset disappears on the next edge. A register value the decoder cannot resolve sends the machine back to its idle state. In that cycle the history gathered so far is dropped. Two event outputs report corrected and uncorrectable register values, one clock after the edge that consumed them. The block is meant for control paths where a radiation-induced upset must neither hang the sequencer nor produce a false detection.

Top module: `ecc_pattern_fsm`

## Requirements
- R1: While `rst_i` is high at a rising edge, the three outputs are low after that edge and the sequencer returns to idle, with no key bits seen.
- R2: `match_o` is high for exactly the one clock that follows the edge consuming a bit, when the last sixteen consumed bits equal `KEY`. The first bit of the key on the wire is `KEY[0]` and the last is `KEY[15]`.
- R3: After a mismatch or a match, the sequencer keeps the longest tail of the received bits that is also a head of the key. Overlapping occurrences of the key therefore each produce a match, and a stream differing from the key in any one bit does not.
- R4: State number n = {d3,d2,d1,d0} is stored as an 8-bit code. Bit 2 holds d0, bit 4 holds d1, bit 5 holds d2 and bit 6 holds d3. Bit 0 is d0^d1^d3, bit 1 is d0^d2^d3, bit 3 is d1^d2^d3, and bit 7 makes the total count of ones even.
- R5: A single bit flip in the stored register value, present at one edge, changes neither the next state nor `match_o`. `fixed_o` is high for the clock after that edge.
- R6: A single bit flip on the encoded next-state value, captured by the register at one edge, leaves `match_o` unchanged. `fixed_o` is high for the clock after the following edge.
- R7: A stored value two bits away from a valid code does not consume that edge's input bit. It drives `fault_o` high and `match_o` low for the next clock, and it restarts the sequencer from idle.
- R8: `fixed_o` and `fault_o` are never high in the same clock.
- R9: A match and a corrected upset at the same edge are both reported: `match_o` and `fixed_o` are high together.
- R10: Once a corrected value has been rewritten, `fixed_o` stays low until a new upset occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| din_i | input | 1 | Serial data, one bit consumed per clock |
| match_o | output | 1 | One-clock pulse when the key has just completed |
| fixed_o | output | 1 | One-clock pulse when a single-bit register error was corrected |
| fault_o | output | 1 | One-clock pulse when the register held an uncorrectable value |

## Verification
The two functions that can fall in the same clock are key completion and correction of an upset. The bench provokes this by streaming the key and flipping one register bit during the cycle in which the sixteenth key bit arrives, once for every bit position. Both `match_o` and `fixed_o` must then be high after that edge. The next pattern step must proceed as if no flip had happened. Random streams built from the key with sparse bit errors and sparse injected single and double flips repeat this check, against a sliding-window model of the last sixteen bits.

// File: rtl/sfsm_pkg.sv
`timescale 1ns/1ps
package sfsm_pkg;

   localparam int STATE_BITS = 4;
   localparam int FULL_CW    = 8;

   // Hamming-coded state word with an even-parity bit on top.
   function automatic logic [FULL_CW-1:0] hamm_enc(input logic [STATE_BITS-1:0] d);
      logic [6:0] c;
      c[0] = d[0] ^ d[1] ^ d[3];
      c[1] = d[0] ^ d[2] ^ d[3];
      c[2] = d[0];
      c[3] = d[1] ^ d[2] ^ d[3];
      c[4] = d[1];
      c[5] = d[2];
      c[6] = d[3];
      return {^c, c};
   endfunction

   // Longest tail of (key head of length s, then b) that is also a key head,
   // capped below the full key length.
   function automatic logic [STATE_BITS-1:0] kmp_next(input logic [15:0] key,
                                                      input int s, input logic b);
      int   best;
      int   p;
      logic ok;
      logic c;
      best = 0;
      for (int k = 1; k <= 15; k++) begin
         if (k <= s + 1) begin
            ok = 1'b1;
            for (int j = 0; j < k; j++) begin
               p = s + 1 - k + j;
               c = (p == s) ? b : key[p];
               if (c != key[j]) ok = 1'b0;
            end
            if (ok) best = k;
         end
      end
      return 4'(best);
   endfunction

endpackage

// File: rtl/sfsm_enc.sv
`timescale 1ns/1ps
module sfsm_enc #(
   parameter bit EXT_PARITY = 1'b1,
   localparam int CW = EXT_PARITY ? 8 : 7
) (
   input  logic [sfsm_pkg::STATE_BITS-1:0] state_i,
   output logic [CW-1:0]                   code_o
);
   logic [sfsm_pkg::FULL_CW-1:0] full;
   assign full = sfsm_pkg::hamm_enc(state_i);

   if (EXT_PARITY) begin : g_ext
      assign code_o = full;
   end else begin : g_plain
      logic unused_par;
      assign unused_par = full[7];
      assign code_o = full[6:0];
   end
endmodule

// File: rtl/sfsm_dec.sv
`timescale 1ns/1ps
module sfsm_dec #(
   parameter bit EXT_PARITY = 1'b1,
   localparam int CW = EXT_PARITY ? 8 : 7
) (
   input  logic [CW-1:0]                   code_i,
   output logic [sfsm_pkg::STATE_BITS-1:0] state_o,
   output logic                            fixed_o,
   output logic                            bad_o
);
   logic [6:0] low;
   logic [2:0] syn;
   logic [6:0] flip;
   logic [6:0] corr;
   logic       use_flip;

   assign low = code_i[6:0];
   assign syn = {low[3] ^ low[4] ^ low[5] ^ low[6],
                 low[1] ^ low[2] ^ low[5] ^ low[6],
                 low[0] ^ low[2] ^ low[4] ^ low[6]};

   always_comb begin
      flip = '0;
      if (syn != 3'd0) flip[syn - 3'd1] = 1'b1;
   end

   if (EXT_PARITY) begin : g_ext
      logic odd;
      assign odd      = ^code_i;
      assign fixed_o  = odd;
      assign bad_o    = (syn != 3'd0) && !odd;
      assign use_flip = (syn != 3'd0) && odd;
   end else begin : g_plain
      assign fixed_o  = (syn != 3'd0);
      assign bad_o    = 1'b0;
      assign use_flip = (syn != 3'd0);
   end

   assign corr    = low ^ (use_flip ? flip : 7'd0);
   assign state_o = {corr[6], corr[5], corr[4], corr[2]};

   logic [sfsm_pkg::FULL_CW-1:0] reenc;
   assign reenc = sfsm_pkg::hamm_enc(state_o);

   always_comb begin
      if (!fixed_o && !bad_o) begin
         assert_clean_roundtrip_R4: assert (code_i == reenc[CW-1:0]);
      end
   end
endmodule

// File: rtl/sfsm_trans.sv
`timescale 1ns/1ps
module sfsm_trans #(
   parameter logic [15:0] KEY = 16'hB2B2
) (
   input  logic [sfsm_pkg::STATE_BITS-1:0] cur_i,
   input  logic                            bit_i,
   output logic [sfsm_pkg::STATE_BITS-1:0] nxt_o,
   output logic                            hit_o
);
   localparam int SB    = sfsm_pkg::STATE_BITS;
   localparam int NST   = 1 << SB;
   localparam int TAB_N = NST * 2;

   logic [SB-1:0] tab [TAB_N];

   for (genvar s = 0; s < NST; s++) begin : g_st
      for (genvar b = 0; b < 2; b++) begin : g_bit
         localparam logic [SB-1:0] NXT = sfsm_pkg::kmp_next(KEY, s, b != 0);
         assign tab[s*2 + b] = NXT;
      end
   end

   assign nxt_o = tab[{cur_i, bit_i}];
   assign hit_o = (cur_i == SB'(NST - 1)) && (bit_i == KEY[15]);

   always_comb begin
      assert_step_bound_R3: assert ({1'b0, nxt_o} <= {1'b0, cur_i} + 5'd1);
   end
endmodule

// File: rtl/ecc_pattern_fsm.sv
`timescale 1ns/1ps
module ecc_pattern_fsm #(
   parameter int              KEY_LEN    = 16,
   parameter logic [15:0]     KEY        = 16'hB2B2,
   parameter bit              EXT_PARITY = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic din_i,
   output logic match_o,
   output logic fixed_o,
   output logic fault_o
);
   localparam int SB = $clog2(KEY_LEN);
   localparam int CW = EXT_PARITY ? 8 : 7;
   localparam logic [SB-1:0] IDLE = '0;

   if (KEY_LEN != 16) begin : g_len_check
      $error("ecc_pattern_fsm: KEY_LEN must be 16 (four data bits per codeword)");
   end

   logic [CW-1:0] code_q, code_seen, code_enc, code_d, idle_code;
   logic [SB-1:0] cur_st, adv_st, nxt_st;
   logic          dec_fixed, dec_bad, adv_hit;
   logic          match_q, fixed_q, fault_q;

   assign code_seen = code_q;

   sfsm_dec #(.EXT_PARITY(EXT_PARITY)) u_dec (
      .code_i (code_seen),
      .state_o(cur_st),
      .fixed_o(dec_fixed),
      .bad_o  (dec_bad)
   );

   sfsm_trans #(.KEY(KEY)) u_trans (
      .cur_i(cur_st),
      .bit_i(din_i),
      .nxt_o(adv_st),
      .hit_o(adv_hit)
   );

   assign nxt_st = dec_bad ? IDLE : adv_st;

   sfsm_enc #(.EXT_PARITY(EXT_PARITY)) u_enc (
      .state_i(nxt_st),
      .code_o (code_enc)
   );

   sfsm_enc #(.EXT_PARITY(EXT_PARITY)) u_enc_idle (
      .state_i(IDLE),
      .code_o (idle_code)
   );

   assign code_d = code_enc;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         code_q  <= idle_code;
         match_q <= 1'b0;
         fixed_q <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         code_q  <= code_d;
         match_q <= adv_hit && !dec_bad;
         fixed_q <= dec_fixed;
         fault_q <= dec_bad;
      end
   end

   assign match_o = match_q;
   assign fixed_o = fixed_q;
   assign fault_o = fault_q;

   assert_flags_exclusive_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      !(fixed_o && fault_o));

   assert_fault_no_match_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      fault_o |-> !match_o);

   assert_fault_to_idle_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      fault_o |-> (code_q == idle_code));

   assert_match_last_bit_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      match_o |-> ($past(din_i) == KEY[15]));
endmodule

// File: tb/ecc_pattern_fsm_tb.sv
`timescale 1ns/1ps
module ecc_pattern_fsm_tb;
   localparam logic [15:0] KEY = 16'hB2B2;

   logic clk = 1'b0;
   logic rst;
   logic din;
   logic match_o, fixed_o, fault_o;
   logic [7:0] inj_val;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   logic [15:0] win;
   int          len;
   int          pend;

   always #5 clk = ~clk;

   ecc_pattern_fsm #(.KEY_LEN(16), .KEY(KEY), .EXT_PARITY(1'b1)) u_dut (
      .clk_i(clk), .rst_i(rst), .din_i(din),
      .match_o(match_o), .fixed_o(fixed_o), .fault_o(fault_o)
   );

   // R4 code layout, written from the requirement text
   function automatic logic [7:0] enc8(input int n);
      logic [3:0] d;
      logic [6:0] c;
      d = 4'(n);
      c[2] = d[0]; c[4] = d[1]; c[5] = d[2]; c[6] = d[3];
      c[0] = d[0] ^ d[1] ^ d[3];
      c[1] = d[0] ^ d[2] ^ d[3];
      c[3] = d[1] ^ d[2] ^ d[3];
      return {^c, c};
   endfunction

   // progress through the key implied by the recent history (w[0] newest)
   function automatic int model_state(input logic [15:0] w, input int n);
      int   best;
      logic ok;
      best = 0;
      for (int k = 1; k <= 15; k++) begin
         if (k <= n) begin
            ok = 1'b1;
            for (int j = 0; j < k; j++) if (w[k-1-j] != KEY[j]) ok = 1'b0;
            if (ok) best = k;
         end
      end
      return best;
   endfunction

   function automatic logic model_full(input logic [15:0] w, input int n);
      logic ok;
      ok = (n >= 16);
      for (int j = 0; j < 16; j++) if (w[15-j] != KEY[j]) ok = 1'b0;
      return ok;
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // kind 0: none, 1: flip stored value, 2: flip next-state value
   task automatic step(input logic b, input int kind, input logic [7:0] mask,
                       input string ctx);
      logic e_fix, e_unc, e_match;
      int   s_cur, wt;
      e_fix = 0; e_unc = 0; e_match = 0;
      wt = $countones(mask);
      s_cur = model_state(win, len);
      din = b;
      if (pend == 2) begin
         e_unc = 1; len = 0; win = '0;
      end else begin
         if (pend == 1) e_fix = 1;
         if (kind == 1) begin
            if (wt == 1) e_fix = 1; else e_unc = 1;
         end
         if (e_unc) begin
            len = 0; win = '0;
         end else begin
            win = {win[14:0], b};
            if (len < 16) len++;
            e_match = model_full(win, len);
         end
      end
      pend = 0;
      if (kind == 1) begin
         inj_val = enc8(s_cur) ^ mask;
         force u_dut.code_seen = inj_val;
      end else if (kind == 2) begin
         inj_val = enc8(model_state(win, len)) ^ mask;
         force u_dut.code_d = inj_val;
         pend = (wt == 1) ? 1 : 2;
      end
      @(posedge clk);
      #1;
      if (kind == 1) release u_dut.code_seen;
      if (kind == 2) release u_dut.code_d;
      @(negedge clk);
      chk({ctx, " R2/R3 match"}, match_o, e_match);
      chk({ctx, (e_fix ? " R5/R6 fixed" : " R10 fixed quiet")}, fixed_o, e_fix);
      chk({ctx, " R7 fault"}, fault_o, e_unc);
      chk({ctx, " R8 exclusive"}, fixed_o & fault_o, 1'b0);
   endtask

   task automatic send_key(input string ctx);
      for (int i = 0; i < 16; i++) step(KEY[i], 0, 8'h00, ctx);
   endtask

   initial begin
      #(60000 * 10);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst = 1; din = 0; inj_val = '0; win = '0; len = 0; pend = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset match", match_o, 1'b0);
      chk("R1 reset fixed", fixed_o, 1'b0);
      chk("R1 reset fault", fault_o, 1'b0);
      rst = 0;

      // R2 plain key, then R3 overlap by half a key
      send_key("R2 key");
      for (int i = 8; i < 16; i++) step(KEY[i], 0, 8'h00, "R3 overlap");
      // R3 near-miss: one bit differs
      for (int i = 0; i < 16; i++) step(i == 5 ? ~KEY[i] : KEY[i], 0, 8'h00, "R3 near miss");
      send_key("R3 recover");

      // R9 / R5: upset on every bit position at the completing edge
      for (int p = 0; p < 8; p++) begin
         for (int i = 0; i < 15; i++) step(KEY[i], 0, 8'h00, "R9 lead");
         step(KEY[15], 1, 8'(1 << p), "R9 match+fix");
         for (int i = 8; i < 16; i++) step(KEY[i], 0, 8'h00, "R5 after fix");
      end

      // R6: upset before the register, mid key
      for (int p = 0; p < 8; p++) begin
         for (int i = 0; i < 16; i++)
            step(KEY[i], (i == 7) ? 2 : 0, (i == 7) ? 8'(1 << p) : 8'h00, "R6 pre-reg");
      end

      // R7: double flips after and before the register
      for (int i = 0; i < 10; i++) step(KEY[i], (i == 6) ? 1 : 0, 8'h81, "R7 double post");
      send_key("R7 restart");
      for (int i = 0; i < 10; i++) step(KEY[i], (i == 3) ? 2 : 0, 8'h0C, "R7 double pre");
      send_key("R7 restart pre");

      // constrained random mix
      begin
         int kp;
         kp = 0;
         for (int n = 0; n < 3000; n++) begin
            logic       b;
            int         kind;
            logic [7:0] m;
            int         i0, i1;
            b = KEY[kp];
            kp = (kp + 1) % 16;
            if ($urandom % 12 == 0) b = ~b;
            kind = 0; m = 8'h00;
            if (pend == 0 && ($urandom % 14 == 0)) begin
               kind = 1 + int'($urandom % 2);
               i0 = int'($urandom % 8);
               m = 8'(1 << i0);
               if ($urandom % 4 == 0) begin
                  i1 = (i0 + 1 + int'($urandom % 7)) % 8;
                  m = m | 8'(1 << i1);
               end
            end
            step(b, kind, m, "random");
         end
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule